// File: doc/BRIEF.md
# Multi-Lane Paged Register Bank

This block is the register front end of a four-lane serial device. A byte-wide parallel port (write enable, read enable, 8-bit address, 8-bit data) reaches one shared page and one page per lane. Each lane page is a full private copy of the lane registers. A single select register at the top address picks the page for every later access. The select register is always reachable. Its value stays in force until software writes it again.

A lane page holds four kinds of register. The first holds per-lane reset controls, including a soft reset that puts that lane's registers back to their defaults. The second holds two sticky event flags that clear when read: loss of lock, and loss of signal. The third holds command bits that fire a one-cycle pulse and read back as zero. The fourth holds plain control fields that are driven out of the block. Some fields have fixed non-zero reset values. Lock and signal-detect inputs come in per lane, and the control fields, reset levels and command pulses go out per lane.

Top module: `paged_reg_bank`

## Requirements
- R1: After reset the select register reads 0x10 (shared page), read data is 0x00, all lane outputs are 0, shared register 0x04 reads 0x3C, and each lane's registers read 0x93 at 0x0E, 0x69 at 0x0F and 0x06 at 0x2F.
- R2: Address 0xFF is the select register from any page. It stores bits 4:0 of a write and reads back with bits 7:5 zero. It keeps its value until it is written again.
- R3: Select bits 3:0 carry one bit per lane, with lane n at bit n. A write reaches every selected lane. A read returns the lowest-numbered selected lane.
- R4: When bits 3:0 are zero and bit 4 is set, accesses go to the shared page, where 0x04 is a read/write control byte. When bits 4:0 are all zero, reads return 0x00 and writes change nothing.
- R5: Lane register 0x00 bits 3, 1 and 0 are read/write and drive that lane's core, reference-domain and divider-domain reset outputs.
- R6: Writing 1 to lane register 0x00 bit 2 restores every register of the written lanes to its default on the next cycle. Other lanes are untouched, and the bit reads back as 0.
- R7: Lane register 0x01 bit 4 (loss of lock) and bit 0 (loss of signal) set only when the matching input was high and then falls. A lane whose inputs never rose shows no flag.
- R8: A read of lane register 0x01 returns the flags and then clears them. A fall that occurs in the same cycle as that read leaves its flag set.
- R9: Writing 1 to lane register 0x2F bit 0, 0x24 bit 2 or 0x24 bit 0 gives exactly one cycle of the matching start pulse. Those bits read as 0. Bits 7:1 of 0x2F are stored, and bits 7:4 drive the lane rate field.
- R10: Reads of unimplemented addresses return 0x00, and writes to them have no effect.
- R11: Read data appears on the cycle after a read is sampled and holds while no read is issued. Lane register 0x02 shows the live lock input at bit 4 and the live signal input at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| lock_in | input | NLANES | Per-lane lock indication |
| sig_in | input | NLANES | Per-lane signal detect |
| lane_rst_core | output | NLANES | Core state machine reset per lane |
| lane_rst_ref | output | NLANES | Reference-clock domain reset per lane |
| lane_rst_div | output | NLANES | Divider-clock domain reset per lane |
| ctle_go | output | NLANES | Equalizer adapt start pulse per lane |
| dfe_go | output | NLANES | Feedback equalizer adapt start pulse per lane |
| eom_go | output | NLANES | Eye monitor start pulse per lane |
| lane_boost | output | 8*NLANES | Boost control byte per lane |
| lane_rate | output | 4*NLANES | Rate field per lane |
| shared_ctrl | output | 8 | Shared page control byte |

## Verification
Two things can land on the same edge: a read of the flag register, and a fresh fall of the lock input. The bench first leaves a loss-of-lock flag set. It then raises lock, and drops it again in the same cycle that it reads register 0x01. The read must return the flag. A second read must still see the flag, and only a third read may return zero. The broadcast path is judged the same way. One write reaches two lanes, and the bench then reads each lane back after narrowing the select.

// File: rtl/prb_pkg.sv
// Package: shared constants for the paged register bank.
// Assumes byte-wide data and an 8-bit address space.
package prb_pkg;
    localparam int DW = 8;
    localparam int AW = 8;

    // Page select register, reachable from every page
    localparam logic [AW-1:0] ADDR_SEL   = 8'hFF;

    // Lane page addresses
    localparam logic [AW-1:0] LA_RESET   = 8'h00;
    localparam logic [AW-1:0] LA_FLAGS   = 8'h01;
    localparam logic [AW-1:0] LA_LIVE    = 8'h02;
    localparam logic [AW-1:0] LA_BOOST   = 8'h03;
    localparam logic [AW-1:0] LA_PADA    = 8'h0E;
    localparam logic [AW-1:0] LA_PADB    = 8'h0F;
    localparam logic [AW-1:0] LA_CMD     = 8'h24;
    localparam logic [AW-1:0] LA_RATE    = 8'h2F;

    // Shared page addresses
    localparam logic [AW-1:0] SA_CTRL    = 8'h04;

    // Reset defaults
    localparam logic [DW-1:0] DEF_PADA   = 8'h93;
    localparam logic [DW-1:0] DEF_PADB   = 8'h69;
    localparam logic [DW-1:0] DEF_RATE   = 8'h06;
    localparam logic [DW-1:0] DEF_SCTRL  = 8'h3C;

    // Bit positions inside the reset register
    localparam int RB_DIV  = 0;
    localparam int RB_REF  = 1;
    localparam int RB_SOFT = 2;
    localparam int RB_CORE = 3;
endpackage

// File: rtl/prb_page_sel.sv
// Module: prb_page_sel
// Holds the sticky page-select register and turns it into write enables
// for the lanes and the shared page, plus a one-hot pick of the lowest
// selected lane for reads.
// Assumes NL <= 7 so the select value fits a byte.
module prb_page_sel
    import prb_pkg::*;
#(
    parameter int NL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [NL:0]   wsel,
    output logic [NL:0]   sel_q,
    output logic          sel_hit,
    output logic [NL-1:0] lane_wr,
    output logic [NL-1:0] lane_pick,
    output logic          lane_any,
    output logic          shared_pick,
    output logic          shared_wr
);
    localparam logic [NL:0] SEL_DEF = {1'b1, {NL{1'b0}}};

    logic [NL-1:0] mask;

    // Select register: only a write to the select address changes it
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= SEL_DEF;
        else if (wr_en && sel_hit)
            sel_q <= wsel;
    end

    // Decode the page and pick the lowest selected lane
    always_comb begin
        sel_hit     = (addr == ADDR_SEL);
        mask        = sel_q[NL-1:0];
        lane_any    = |mask;
        lane_pick   = mask & (~mask + 1'b1);
        shared_pick = !lane_any && sel_q[NL];
        lane_wr     = (wr_en && !sel_hit) ? mask : '0;
        shared_wr   = wr_en && !sel_hit && shared_pick;
    end
endmodule

// File: rtl/prb_lane_regs.sv
// Module: prb_lane_regs
// One lane's register page: reset controls with a soft default restore,
// sticky clear-on-read loss flags, self-clearing command pulses and
// exported control fields.
// Assumes wr and rd_clr are already qualified by the page decode.
module prb_lane_regs
    import prb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd_clr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          lock_in,
    input  logic          sig_in,
    output logic [DW-1:0] rd_val,
    output logic          rst_core,
    output logic          rst_ref,
    output logic          rst_div,
    output logic          ctle_go,
    output logic          dfe_go,
    output logic          eom_go,
    output logic [DW-1:0] boost,
    output logic [3:0]    rate,
    output logic          lol_flag,
    output logic          los_flag
);
    logic          soft_rst;
    logic [DW-1:0] pad_a, pad_b;
    logic [DW-2:0] rate_q;
    logic          lock_q, sig_q;
    logic          lol_evt, los_evt;

    assign soft_rst = wr && (addr == LA_RESET) && wdata[RB_SOFT];
    assign lol_evt  = lock_q && !lock_in;
    assign los_evt  = sig_q && !sig_in;
    assign rate     = rate_q[DW-2 -: 4];

    // Plain read/write fields, restored by hard or soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            rst_core <= 1'b0;
            rst_ref  <= 1'b0;
            rst_div  <= 1'b0;
            boost    <= '0;
            pad_a    <= DEF_PADA;
            pad_b    <= DEF_PADB;
            rate_q   <= DEF_RATE[DW-1:1];
        end else if (wr) begin
            case (addr)
                LA_RESET: begin
                    rst_core <= wdata[RB_CORE];
                    rst_ref  <= wdata[RB_REF];
                    rst_div  <= wdata[RB_DIV];
                end
                LA_BOOST: boost  <= wdata;
                LA_PADA:  pad_a  <= wdata;
                LA_PADB:  pad_b  <= wdata;
                LA_RATE:  rate_q <= wdata[DW-1:1];
                default:  ;
            endcase
        end
    end

    // Command pulses: high for the one cycle after the commanding write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctle_go <= 1'b0;
            dfe_go  <= 1'b0;
            eom_go  <= 1'b0;
        end else begin
            ctle_go <= wr && (addr == LA_RATE) && wdata[0];
            dfe_go  <= wr && (addr == LA_CMD)  && wdata[2];
            eom_go  <= wr && (addr == LA_CMD)  && wdata[0];
        end
    end

    // Input history for loss detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            sig_q  <= 1'b0;
        end else begin
            lock_q <= lock_in;
            sig_q  <= sig_in;
        end
    end

    // Sticky flags: a new event in the clearing cycle wins over the clear
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            lol_flag <= 1'b0;
            los_flag <= 1'b0;
        end else begin
            lol_flag <= (lol_flag && !rd_clr) || lol_evt;
            los_flag <= (los_flag && !rd_clr) || los_evt;
        end
    end

    // Read value for the current address
    always_comb begin
        case (addr)
            LA_RESET: rd_val = {4'b0, rst_core, 1'b0, rst_ref, rst_div};
            LA_FLAGS: rd_val = {3'b0, lol_flag, 3'b0, los_flag};
            LA_LIVE:  rd_val = {3'b0, lock_in, 3'b0, sig_in};
            LA_BOOST: rd_val = boost;
            LA_PADA:  rd_val = pad_a;
            LA_PADB:  rd_val = pad_b;
            LA_RATE:  rd_val = {rate_q, 1'b0};
            default:  rd_val = '0;
        endcase
    end
endmodule

// File: rtl/prb_shared_regs.sv
// Module: prb_shared_regs
// The shared page: one read/write control byte with a non-zero default.
// Assumes wr is already qualified by the page decode.
module prb_shared_regs
    import prb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] ctrl
);
    // Shared control byte storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= DEF_SCTRL;
        else if (wr && addr == SA_CTRL)
            ctrl <= wdata;
    end

    // Read value for the current address
    always_comb begin
        rd_val = (addr == SA_CTRL) ? ctrl : '0;
    end
endmodule

// File: rtl/paged_reg_bank.sv
// Module: paged_reg_bank (top)
// A byte-wide register port in front of a shared page and NLANES lane pages,
// steered by a sticky page-select register at the top address.
// Assumes single-cycle wr_en/rd_en strobes; read data is registered.
module paged_reg_bank
    import prb_pkg::*;
#(
    parameter int NLANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [7:0]           addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    input  logic [NLANES-1:0]    lock_in,
    input  logic [NLANES-1:0]    sig_in,
    output logic [NLANES-1:0]    lane_rst_core,
    output logic [NLANES-1:0]    lane_rst_ref,
    output logic [NLANES-1:0]    lane_rst_div,
    output logic [NLANES-1:0]    ctle_go,
    output logic [NLANES-1:0]    dfe_go,
    output logic [NLANES-1:0]    eom_go,
    output logic [8*NLANES-1:0]  lane_boost,
    output logic [4*NLANES-1:0]  lane_rate,
    output logic [7:0]           shared_ctrl
);
    localparam int SELW = NLANES + 1;
    localparam int PADW = DW - SELW;

    logic [SELW-1:0]   sel_q;
    logic              sel_hit, lane_any, shared_pick, shared_wr;
    logic [NLANES-1:0] lane_wr, lane_pick, rd_clr;
    logic [NLANES-1:0] lol_flag, los_flag;
    logic [DW-1:0]     lane_rd [NLANES];
    logic [DW-1:0]     shared_rd, lane_mux;

    prb_page_sel #(.NL(NLANES)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wsel        (wdata[SELW-1:0]),
        .sel_q       (sel_q),
        .sel_hit     (sel_hit),
        .lane_wr     (lane_wr),
        .lane_pick   (lane_pick),
        .lane_any    (lane_any),
        .shared_pick (shared_pick),
        .shared_wr   (shared_wr)
    );

    prb_shared_regs u_shared (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (shared_wr),
        .addr   (addr),
        .wdata  (wdata),
        .rd_val (shared_rd),
        .ctrl   (shared_ctrl)
    );

    generate
        for (genvar g = 0; g < NLANES; g++) begin : g_lane
            // Flags clear only in the lane whose value is returned
            assign rd_clr[g] = rd_en && !sel_hit && lane_pick[g] && (addr == LA_FLAGS);

            prb_lane_regs u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr       (lane_wr[g]),
                .rd_clr   (rd_clr[g]),
                .addr     (addr),
                .wdata    (wdata),
                .lock_in  (lock_in[g]),
                .sig_in   (sig_in[g]),
                .rd_val   (lane_rd[g]),
                .rst_core (lane_rst_core[g]),
                .rst_ref  (lane_rst_ref[g]),
                .rst_div  (lane_rst_div[g]),
                .ctle_go  (ctle_go[g]),
                .dfe_go   (dfe_go[g]),
                .eom_go   (eom_go[g]),
                .boost    (lane_boost[8*g +: 8]),
                .rate     (lane_rate[4*g +: 4]),
                .lol_flag (lol_flag[g]),
                .los_flag (los_flag[g])
            );
        end
    endgenerate

    // Select the read value of the lowest selected lane
    always_comb begin
        lane_mux = '0;
        for (int i = 0; i < NLANES; i++)
            if (lane_pick[i]) lane_mux = lane_mux | lane_rd[i];
    end

    // Registered read data, updated only on a read
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en) begin
            if (sel_hit)          rdata <= {{PADW{1'b0}}, sel_q};
            else if (lane_any)    rdata <= lane_mux;
            else if (shared_pick) rdata <= shared_rd;
            else                  rdata <= '0;
        end
    end
endmodule

// File: rtl/prb_checker.sv
// Module: prb_checker
// Temporal checks on the paged register bank, bound to the top module.
module prb_checker #(
    parameter int NL = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [7:0]    addr,
    input logic [7:0]    wdata,
    input logic [7:0]    rdata,
    input logic [NL:0]   sel_q,
    input logic [NL-1:0] lock_in,
    input logic [NL-1:0] lol_flag,
    input logic [NL-1:0] ctle_go
);
    localparam logic [NL:0] SEL_DEF = {1'b1, {NL{1'b0}}};

    // R1: first cycle after reset shows the shared page selected
    p_reset_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sel_q == SEL_DEF));

    // R2: select value only moves on a write to the select address
    p_sel_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 8'hFF) |=> $stable(sel_q));

    // R4: nothing selected means reads return zero
    p_none_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != 8'hFF && sel_q == '0) |=> (rdata == 8'h00));

    generate
        for (genvar g = 0; g < NL; g++) begin : g_chk
            // R7: a loss-of-lock flag rises only after lock was held and dropped
            p_lol_after_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(lol_flag[g]) |-> ($past(lock_in[g], 2) && !$past(lock_in[g])));

            // R9: an adapt pulse follows a write of bit 0 to the rate register
            p_ctle_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
                ctle_go[g] |-> $past(wr_en && addr == 8'h2F && wdata[0]));
        end
    endgenerate
endmodule

bind paged_reg_bank prb_checker #(.NL(NLANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .sel_q    (sel_q),
    .lock_in  (lock_in),
    .lol_flag (lol_flag),
    .ctle_go  (ctle_go)
);

// File: tb/sim_paged_reg_bank.sv
// Bench: table-driven register accesses, then directed corner cases.
module sim_paged_reg_bank;
    localparam int NL = 4;
    localparam int NV = 43;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]    addr = '0, wdata = '0;
    logic [7:0]    rdata;
    logic [NL-1:0] lock_in = '0, sig_in = '0;
    logic [NL-1:0] lane_rst_core, lane_rst_ref, lane_rst_div;
    logic [NL-1:0] ctle_go, dfe_go, eom_go;
    logic [8*NL-1:0] lane_boost;
    logic [4*NL-1:0] lane_rate;
    logic [7:0]    shared_ctrl;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    paged_reg_bank #(.NLANES(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .lock_in(lock_in), .sig_in(sig_in),
        .lane_rst_core(lane_rst_core), .lane_rst_ref(lane_rst_ref),
        .lane_rst_div(lane_rst_div), .ctle_go(ctle_go), .dfe_go(dfe_go),
        .eom_go(eom_go), .lane_boost(lane_boost), .lane_rate(lane_rate),
        .shared_ctrl(shared_ctrl)
    );

    // Vector: {is_write, addr, wdata, expected read, requirement number}
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 8'hFF, 8'h00, 8'h10, 4'd1},   // R1 select default
        {1'b0, 8'h04, 8'h00, 8'h3C, 4'd1},   // R1 shared default
        {1'b1, 8'h04, 8'h55, 8'h00, 4'd4},
        {1'b0, 8'h04, 8'h00, 8'h55, 4'd4},   // R4 shared write
        {1'b1, 8'hFF, 8'h01, 8'h00, 4'd2},
        {1'b0, 8'hFF, 8'h00, 8'h01, 4'd2},   // R2 select readback
        {1'b0, 8'h0E, 8'h00, 8'h93, 4'd1},   // R1 lane default
        {1'b0, 8'h0F, 8'h00, 8'h69, 4'd1},
        {1'b0, 8'h2F, 8'h00, 8'h06, 4'd1},
        {1'b1, 8'h03, 8'hA1, 8'h00, 4'd3},
        {1'b0, 8'h03, 8'h00, 8'hA1, 4'd3},   // R3 lane0
        {1'b1, 8'hFF, 8'h02, 8'h00, 4'd3},
        {1'b0, 8'h03, 8'h00, 8'h00, 4'd3},   // R3 lane1 untouched
        {1'b1, 8'hFF, 8'h0C, 8'h00, 4'd3},
        {1'b1, 8'h03, 8'h77, 8'h00, 4'd3},   // R3 broadcast to lanes 2,3
        {1'b1, 8'hFF, 8'h08, 8'h00, 4'd3},
        {1'b0, 8'h03, 8'h00, 8'h77, 4'd3},
        {1'b1, 8'hFF, 8'h04, 8'h00, 4'd3},
        {1'b0, 8'h03, 8'h00, 8'h77, 4'd3},
        {1'b1, 8'hFF, 8'h06, 8'h00, 4'd3},
        {1'b0, 8'h03, 8'h00, 8'h00, 4'd3},   // R3 lowest lane is 1
        {1'b1, 8'hFF, 8'h05, 8'h00, 4'd3},
        {1'b0, 8'h03, 8'h00, 8'hA1, 4'd3},   // R3 lowest lane is 0
        {1'b1, 8'hFF, 8'h00, 8'h00, 4'd4},
        {1'b0, 8'h03, 8'h00, 8'h00, 4'd4},   // R4 none selected
        {1'b1, 8'h03, 8'h99, 8'h00, 4'd4},
        {1'b1, 8'hFF, 8'h01, 8'h00, 4'd4},
        {1'b0, 8'h03, 8'h00, 8'hA1, 4'd4},   // R4 write was ignored
        {1'b1, 8'hFF, 8'h10, 8'h00, 4'd4},
        {1'b0, 8'h04, 8'h00, 8'h55, 4'd4},
        {1'b1, 8'hFF, 8'h01, 8'h00, 4'd10},
        {1'b0, 8'h50, 8'h00, 8'h00, 4'd10},  // R10 unimplemented
        {1'b1, 8'h50, 8'hFF, 8'h00, 4'd10},
        {1'b0, 8'h50, 8'h00, 8'h00, 4'd10},
        {1'b1, 8'h2F, 8'hF1, 8'h00, 4'd9},
        {1'b0, 8'h2F, 8'h00, 8'hF0, 4'd9},   // R9 command bit reads 0
        {1'b1, 8'h24, 8'h05, 8'h00, 4'd9},
        {1'b0, 8'h24, 8'h00, 8'h00, 4'd9},
        {1'b1, 8'h00, 8'h0B, 8'h00, 4'd5},
        {1'b0, 8'h00, 8'h00, 8'h0B, 4'd5},   // R5 reset bits
        {1'b0, 8'hFF, 8'h00, 8'h01, 4'd2},   // R2 still sticky
        {1'b1, 8'hFF, 8'hE1, 8'h00, 4'd2},
        {1'b0, 8'hFF, 8'h00, 8'h01, 4'd2}    // R2 upper bits not stored
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Write: drive at a falling edge, release at the next one
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read: data is valid at the falling edge after the sampling edge
    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [28:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state at the ports
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 go", {ctle_go, dfe_go, eom_go}, '0);
        chk("R1 resets", {lane_rst_core, lane_rst_ref, lane_rst_div}, '0);
        chk("R1 boost", lane_boost, '0);
        chk("R1 rate", lane_rate, '0);
        chk("R1 shared", shared_ctrl, 8'h3C);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            if (v[28]) wr(v[27:20], v[19:12]);
            else begin
                rd(v[27:20], r);
                chk($sformatf("R%0d vec%0d", v[3:0], i), r, v[11:4]);
            end
        end

        // Port-level results of the table
        chk("R5 core", lane_rst_core[0], 1'b1);
        chk("R5 ref", lane_rst_ref[0], 1'b1);
        chk("R5 div", lane_rst_div[0], 1'b1);
        chk("R3 boosts", lane_boost, 32'h7777_00A1);
        chk("R9 rate", lane_rate[3:0], 4'hF);
        chk("R4 shared out", shared_ctrl, 8'h55);

        // R11 read data holds while no read is issued
        rd(8'h03, r);
        repeat (3) @(negedge clk);
        chk("R11 hold", rdata, 8'hA1);

        // R9 pulses on two lanes at once, for one cycle only
        wr(8'hFF, 8'h03);
        wr(8'h2F, 8'h01);
        chk("R9 ctle pulse", ctle_go, 4'b0011);
        chk("R9 no dfe", dfe_go, 4'b0000);
        @(negedge clk);
        chk("R9 ctle one cycle", ctle_go, 4'b0000);
        wr(8'h24, 8'h04);
        chk("R9 dfe pulse", {dfe_go, eom_go}, 8'b0011_0000);
        @(negedge clk);
        chk("R9 dfe one cycle", dfe_go, 4'b0000);

        // R6 soft reset of lane 0 only
        wr(8'hFF, 8'h01);
        wr(8'h0E, 8'h11);
        wr(8'h00, 8'h0F);
        rd(8'h03, r); chk("R6 boost", r, 8'h00);
        rd(8'h0E, r); chk("R6 pad", r, 8'h93);
        rd(8'h2F, r); chk("R6 rate", r, 8'h06);
        rd(8'h00, r); chk("R6 reset reg", r, 8'h00);
        chk("R6 other lanes", lane_boost[31:8], 24'h7777_00);

        // R7 no flag before anything was acquired
        rd(8'h01, r); chk("R7 idle", r, 8'h00);
        // R11 live status
        @(negedge clk); sig_in[0] = 1'b1;
        rd(8'h02, r); chk("R11 live", r, 8'h01);
        // R7 lose lock and signal after acquiring them
        @(negedge clk); lock_in[0] = 1'b1;
        @(negedge clk); lock_in[0] = 1'b0; sig_in[0] = 1'b0;
        @(negedge clk);
        rd(8'h01, r); chk("R7 flags", r, 8'h11);
        rd(8'h01, r); chk("R8 cleared", r, 8'h00);

        // R8 new loss in the clearing cycle survives
        @(negedge clk); lock_in[0] = 1'b1;
        @(negedge clk); lock_in[0] = 1'b0;
        @(negedge clk); lock_in[0] = 1'b1;
        @(negedge clk);
        lock_in[0] = 1'b0; rd_en = 1'b1; addr = 8'h01;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R8 read", rdata, 8'h10);
        rd(8'h01, r); chk("R8 kept", r, 8'h10);
        rd(8'h01, r); chk("R8 now clear", r, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule